// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This unit decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may move on to execute. The five stages are fetch, decode with register read, execute, memory access and writeback. The unit compares the source registers of the decode-stage instruction with the destinations of the instructions now in execute and in memory. When a result cannot reach the consumer in time, the unit holds the program counter and the fetch/decode register and puts a no-op bubble into execute.

A static mode input says whether the datapath has full bypass paths from the memory and writeback stages. With bypassing, only a load followed at once by a user stalls, and a branch stalls on an operand that the execute stage is still computing. Without bypassing, a consumer waits in decode until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second, so a value written in writeback is seen by decode in the same cycle. In both modes the unit also produces the ALU operand bypass selects for the instruction in execute. These selects are computed while the instruction is still in decode and are registered as it moves forward.

The one instruction after a branch is a delay slot and always runs, so the unit never flushes it. Branches and stores write no register and cause no hazard downstream. A branch passes through the memory stage as a no-op.

Top module: `hz_ctrl`

## Requirements
- R1: After a synchronous active-high reset both bypass selects read 00. While every stage holds a no-op (class code 0), `if_hold` and `ex_bubble` are 0. Class codes are 0 no-op, 1 ALU, 2 load, 3 store, 4 branch.
- R2: With bypassing on, a non-branch instruction that reads the result of the ALU instruction directly ahead of it is not stalled. In the next cycle the select for that operand reads 01, which means from the memory stage. Select codes are 00 register file, 01 memory stage, 10 writeback stage.
- R3: With bypassing on, a non-branch instruction that reads the destination of the load directly ahead of it is held exactly one cycle. Its select then reads 10 once it is in execute.
- R4: With bypassing on, a branch is held one cycle when its operand comes from the ALU instruction directly ahead of it. It is held two cycles when the operand comes from a load directly ahead of it.
- R5: With bypassing off, a used operand written by the instruction in execute or in memory holds decode. This gives two stall cycles at distance one, one at distance two and none at distance three. Both selects stay 00.
- R6: Register 0 is never a hazard source and is never bypassed. Its select is 00 and it causes no hold.
- R7: When the instructions in execute and in memory both write the needed register, the select for that operand reads 01.
- R8: A stall asserts `if_hold` and `ex_bubble` together. In the cycle after a stall both selects read 00, because a bubble is in execute.
- R9: A store or branch in execute or memory causes no hold and no bypass, even when its destination field matches a source.
- R10: The delay-slot instruction after a branch is never held on the branch's account. Take two loads, two dependent adds, a branch and its delay slot, each using the previous results. The per-instruction stalls are 0,0,1,0,1,0 with bypassing and 0,0,2,2,2,0 without, for last writebacks at cycle 12 and cycle 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | Static mode: 1 when bypass paths exist |
| dec_cls | input | 3 | Class of the decode-stage instruction |
| dec_rs1 | input | REG_AW | First source register of the decode-stage instruction |
| dec_rs2 | input | REG_AW | Second source register of the decode-stage instruction |
| ex_cls | input | 3 | Class of the execute-stage instruction |
| ex_rd | input | REG_AW | Destination field of the execute-stage instruction |
| mem_cls | input | 3 | Class of the memory-stage instruction |
| mem_rd | input | REG_AW | Destination field of the memory-stage instruction |
| if_hold | output | 1 | Hold the program counter and the fetch/decode register |
| ex_bubble | output | 1 | Load a no-op into execute |
| byp_a | output | 2 | Operand A select for the instruction in execute |
| byp_b | output | 2 | Operand B select for the instruction in execute |

## Verification
The assertions assume that the stage inputs come from a pipeline that obeys the unit's own outputs. After a hold, execute carries a no-op. Execute and memory hold the instructions that left decode one and two cycles earlier. The mode does not change between resets. The bench meets these conditions by building every stimulus from a timing schedule worked out from the requirements, in which each instruction's execute cycle follows from the producers it depends on. It applies the mode only while reset is held.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

    typedef enum logic [2:0] {
        CLS_NOP    = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } op_cls_e;

    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_MEM = 2'b01,
        BYP_WB  = 2'b10
    } byp_sel_e;

    // Per-operand match against producers in later stages
    typedef struct packed {
        logic ex_alu;
        logic ex_load;
        logic mem_alu;
        logic mem_load;
    } dep_hits_t;

    function automatic logic cls_reads_a(op_cls_e c);
        case (c)
            CLS_ALU, CLS_LOAD, CLS_STORE, CLS_BRANCH: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic cls_reads_b(op_cls_e c);
        case (c)
            CLS_ALU, CLS_STORE, CLS_BRANCH: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    function automatic logic cls_writes(op_cls_e c);
        case (c)
            CLS_ALU, CLS_LOAD: return 1'b1;
            default:           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hz_dep_match.sv
`timescale 1ns/1ps
module hz_dep_match
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              used,
    input  op_cls_e           ex_cls,
    input  logic [REG_AW-1:0] ex_rd,
    input  op_cls_e           mem_cls,
    input  logic [REG_AW-1:0] mem_rd,
    output dep_hits_t         hits
);

    logic live;
    logic ex_hit;
    logic mem_hit;

    // Register 0 is hard-wired and never a dependence
    assign live    = used && (src != '0);
    assign ex_hit  = live && cls_writes(ex_cls)  && (ex_rd  == src);
    assign mem_hit = live && cls_writes(mem_cls) && (mem_rd == src);

    always_comb begin
        hits          = '0;
        hits.ex_alu   = ex_hit  && (ex_cls  == CLS_ALU);
        hits.ex_load  = ex_hit  && (ex_cls  == CLS_LOAD);
        hits.mem_alu  = mem_hit && (mem_cls == CLS_ALU);
        hits.mem_load = mem_hit && (mem_cls == CLS_LOAD);
    end

endmodule

// File: rtl/hz_stall_decide.sv
`timescale 1ns/1ps
module hz_stall_decide
    import hz_pkg::*;
(
    input  logic      fwd_en,
    input  op_cls_e   dec_cls,
    input  dep_hits_t hits_a,
    input  dep_hits_t hits_b,
    output logic      stall
);

    dep_hits_t any;
    logic      is_branch;
    logic      stall_fwd;
    logic      stall_nofwd;

    assign any       = hits_a | hits_b;
    assign is_branch = (dec_cls == CLS_BRANCH);

    // Bypassed: loads cost a cycle; branch compare in decode also waits
    // for an ALU result still in execute or load data still in memory
    assign stall_fwd = any.ex_load
                     || (is_branch && (any.ex_alu || any.mem_load));

    // No bypass: wait until the producer is in writeback
    assign stall_nofwd = any.ex_alu || any.ex_load
                      || any.mem_alu || any.mem_load;

    assign stall = fwd_en ? stall_fwd : stall_nofwd;

endmodule

// File: rtl/hz_bypass_reg.sv
`timescale 1ns/1ps
module hz_bypass_reg
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fwd_en,
    input  logic     stall,
    input  logic     from_ex,
    input  logic     from_mem,
    output byp_sel_e sel
);

    byp_sel_e nxt;

    // The producer now in execute will be in memory next cycle; the
    // producer now in memory will be in writeback. Nearer one wins.
    always_comb begin
        nxt = BYP_RF;
        if (fwd_en && !stall) begin
            if (from_ex)
                nxt = BYP_MEM;
            else if (from_mem)
                nxt = BYP_WB;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel <= BYP_RF;
        else
            sel <= nxt;
    end

    p_bubble_rf_r8: assert property (@(posedge clk) disable iff (rst)
        $past(stall) |-> (sel == BYP_RF));

    p_nofwd_rf_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(fwd_en) |-> (sel == BYP_RF));

    p_mem_first_r7: assert property (@(posedge clk) disable iff (rst)
        $past(fwd_en && !stall && from_ex && from_mem) |-> (sel == BYP_MEM));

    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        sel != byp_sel_e'(2'b11));

endmodule

// File: rtl/hz_ctrl.sv
`timescale 1ns/1ps
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwd_en,
    input  logic [2:0]        dec_cls,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic [2:0]        ex_cls,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic [2:0]        mem_cls,
    input  logic [REG_AW-1:0] mem_rd,
    output logic              if_hold,
    output logic              ex_bubble,
    output logic [1:0]        byp_a,
    output logic [1:0]        byp_b
);

    localparam int N_OPND = 2;

    op_cls_e           dcls, ecls, mcls;
    logic [REG_AW-1:0] src   [N_OPND];
    logic              used  [N_OPND];
    dep_hits_t         hits  [N_OPND];
    byp_sel_e          sel   [N_OPND];
    logic              stall;

    assign dcls = op_cls_e'(dec_cls);
    assign ecls = op_cls_e'(ex_cls);
    assign mcls = op_cls_e'(mem_cls);

    assign src[0]  = dec_rs1;
    assign src[1]  = dec_rs2;
    assign used[0] = cls_reads_a(dcls);
    assign used[1] = cls_reads_b(dcls);

    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
            hz_dep_match #(.REG_AW(REG_AW)) u_match (
                .src     (src[g]),
                .used    (used[g]),
                .ex_cls  (ecls),
                .ex_rd   (ex_rd),
                .mem_cls (mcls),
                .mem_rd  (mem_rd),
                .hits    (hits[g])
            );

            hz_bypass_reg u_byp (
                .clk      (clk),
                .rst      (rst),
                .fwd_en   (fwd_en),
                .stall    (stall),
                .from_ex  (hits[g].ex_alu),
                .from_mem (hits[g].mem_alu || hits[g].mem_load),
                .sel      (sel[g])
            );
        end
    endgenerate

    hz_stall_decide u_stall (
        .fwd_en  (fwd_en),
        .dec_cls (dcls),
        .hits_a  (hits[0]),
        .hits_b  (hits[1]),
        .stall   (stall)
    );

    assign if_hold   = stall;
    assign ex_bubble = stall;
    assign byp_a     = sel[0];
    assign byp_b     = sel[1];

    p_load_use_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && ecls == CLS_LOAD && ex_rd != '0
         && ((cls_reads_a(dcls) && dec_rs1 == ex_rd)
          || (cls_reads_b(dcls) && dec_rs2 == ex_rd))) |-> if_hold);

    p_branch_alu_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && dcls == CLS_BRANCH && ecls == CLS_ALU && ex_rd != '0
         && (dec_rs1 == ex_rd || dec_rs2 == ex_rd)) |-> if_hold);

    p_nofwd_mem_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!fwd_en && cls_writes(mcls) && mem_rd != '0
         && cls_reads_a(dcls) && dec_rs1 == mem_rd) |-> if_hold);

    p_r0_no_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_rs1 == '0) |=> (byp_a == BYP_RF));

    p_alu_chain_free_r2: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && dcls == CLS_ALU && ecls != CLS_LOAD) |-> !if_hold);

endmodule

// File: tb/hz_ctrl_test.sv
`timescale 1ns/1ps
module hz_ctrl_test;
    import hz_pkg::*;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          fwd_en;
    logic [2:0]    dec_cls, ex_cls, mem_cls;
    logic [AW-1:0] dec_rs1, dec_rs2, ex_rd, mem_rd;
    logic          if_hold, ex_bubble;
    logic [1:0]    byp_a, byp_b;

    always #10 clk = ~clk;

    hz_ctrl #(.REG_AW(AW)) uut (
        .clk(clk), .rst(rst), .fwd_en(fwd_en),
        .dec_cls(dec_cls), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .ex_cls(ex_cls), .ex_rd(ex_rd), .mem_cls(mem_cls), .mem_rd(mem_rd),
        .if_hold(if_hold), .ex_bubble(ex_bubble), .byp_a(byp_a), .byp_b(byp_b)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    int    p_cls [16];
    int    p_rd  [16];
    int    p_rs1 [16];
    int    p_rs2 [16];
    string p_tag [16];
    int    n_ins;
    int    ex_c  [16];
    int    meas  [16];

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL R1 watchdog expired: got 0 expected 1");
        report();
        $finish;
    end

    // Specification of operand use and register writes, by class code
    function automatic bit b_reads(int c, int o);
        if (o == 1) return (c == 1 || c == 2 || c == 3 || c == 4);
        return (c == 1 || c == 3 || c == 4);
    endfunction

    function automatic bit b_writes(int c);
        return (c == 1 || c == 2);
    endfunction

    function automatic int opnd(int j, int o);
        return (o == 1) ? p_rs1[j] : p_rs2[j];
    endfunction

    task automatic ld(int i, int c, int rd, int rs1, int rs2, string tag);
        p_cls[i] = c; p_rd[i] = rd; p_rs1[i] = rs1; p_rs2[i] = rs2; p_tag[i] = tag;
    endtask

    // Earliest execute cycle of each instruction from producer timing
    task automatic plan(bit fwd);
        for (int j = 0; j < n_ins; j++) begin
            int base = (j == 0) ? 3 : ex_c[j-1] + 1;
            int e = base;
            for (int o = 1; o <= 2; o++) begin
                int s = opnd(j, o);
                if (b_reads(p_cls[j], o) && s != 0) begin
                    for (int k = 0; k < j; k++) begin
                        if (b_writes(p_cls[k]) && p_rd[k] == s) begin
                            int need;
                            if (!fwd)              need = 3;
                            else if (p_cls[j] == 4) need = (p_cls[k] == 2) ? 3 : 2;
                            else                   need = (p_cls[k] == 2) ? 2 : 1;
                            if (ex_c[k] + need > e) e = ex_c[k] + need;
                        end
                    end
                end
            end
            ex_c[j] = e;
        end
    endtask

    function automatic int exp_code(int j, int o, bit fwd);
        int s = opnd(j, o);
        if (!fwd || !b_reads(p_cls[j], o) || s == 0) return 0;
        for (int k = j - 1; k >= 0; k--) begin
            if (b_writes(p_cls[k]) && p_rd[k] == s) begin
                int d = ex_c[j] - ex_c[k];
                if (d == 1) return 1;
                if (d == 2) return 2;
                return 0;
            end
        end
        return 0;
    endfunction

    task automatic drive_nop();
        dec_cls = 3'd0; dec_rs1 = '0; dec_rs2 = '0;
        ex_cls = 3'd0; ex_rd = '0; mem_cls = 3'd0; mem_rd = '0;
    endtask

    task automatic run_prog(bit fwd);
        int last;
        @(negedge clk);
        rst = 1'b1; fwd_en = fwd; drive_nop();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", "reset byp_a", byp_a, 0);
        check("R1", "reset byp_b", byp_b, 0);
        check("R1", "idle if_hold", if_hold, 0);
        plan(fwd);
        for (int j = 0; j < n_ins; j++) meas[j] = 0;
        last = ex_c[n_ins-1] + 2;
        for (int t = 1; t <= last; t++) begin
            int idj = -1, exj = -1, mmj = -1;
            int eh;
            string tg;
            @(negedge clk);
            for (int j = 0; j < n_ins; j++) begin
                int ent = (j == 0) ? 2 : ex_c[j-1];
                if (t >= ent && t <= ex_c[j] - 1) idj = j;
                if (ex_c[j] == t)     exj = j;
                if (ex_c[j] + 1 == t) mmj = j;
            end
            drive_nop();
            if (idj >= 0) begin
                dec_cls = 3'(p_cls[idj]); dec_rs1 = AW'(p_rs1[idj]); dec_rs2 = AW'(p_rs2[idj]);
            end
            if (exj >= 0) begin ex_cls = 3'(p_cls[exj]);  ex_rd = AW'(p_rd[exj]);  end
            if (mmj >= 0) begin mem_cls = 3'(p_cls[mmj]); mem_rd = AW'(p_rd[mmj]); end
            #2;
            eh = (idj >= 0 && t < ex_c[idj] - 1) ? 1 : 0;
            tg = (idj < 0) ? "R8" : (fwd ? p_tag[idj] : "R5");
            check(tg, $sformatf("if_hold cycle %0d", t), if_hold, eh);
            check("R8", $sformatf("ex_bubble cycle %0d", t), ex_bubble, eh);
            if (idj >= 0) meas[idj] += int'(if_hold);
            tg = (exj < 0) ? "R8" : (fwd ? p_tag[exj] : "R5");
            check(tg, $sformatf("byp_a cycle %0d", t), byp_a,
                  (exj >= 0) ? exp_code(exj, 1, fwd) : 0);
            check(tg, $sformatf("byp_b cycle %0d", t), byp_b,
                  (exj >= 0) ? exp_code(exj, 2, fwd) : 0);
        end
    endtask

    task automatic load_p1();
        n_ins = 6;
        ld(0, 2, 1, 0, 0, "R2");   // load r1
        ld(1, 2, 2, 0, 0, "R2");   // load r2
        ld(2, 1, 3, 1, 2, "R3");   // add r3 = r1 + r2 (load-use)
        ld(3, 1, 4, 3, 1, "R2");   // add r4 = r3 + r1 (ALU chain)
        ld(4, 4, 0, 3, 4, "R4");   // branch on r3, r4
        ld(5, 1, 3, 3, 3, "R10");  // delay slot
    endtask

    task automatic load_p2();
        n_ins = 9;
        ld(0, 1, 0, 1, 2, "R6");   // writes r0: no effect
        ld(1, 1, 3, 0, 0, "R6");   // reads r0 only
        ld(2, 3, 5, 3, 3, "R2");   // store, reads r3 from ALU ahead
        ld(3, 1, 4, 5, 5, "R9");   // r5 matches only the store's field
        ld(4, 1, 4, 3, 1, "R2");
        ld(5, 1, 6, 4, 4, "R7");   // r4 written at distance 1 and 2
        ld(6, 2, 7, 6, 0, "R2");   // load r7
        ld(7, 4, 8, 7, 6, "R4");   // branch on freshly loaded r7
        ld(8, 1, 9, 8, 7, "R10");  // delay slot, r8 is the branch's field
    endtask

    initial begin
        int exp_f [6] = '{0, 0, 1, 0, 1, 0};
        int exp_n [6] = '{0, 0, 2, 2, 2, 0};
        int tot;
        rst = 1'b1; fwd_en = 1'b1; drive_nop();

        load_p1();
        run_prog(1'b1);
        tot = 0;
        for (int j = 0; j < 6; j++) begin
            check("R10", $sformatf("bypassed stalls instr %0d", j), meas[j], exp_f[j]);
            tot += meas[j];
        end
        check("R10", "bypassed last writeback cycle", 10 + tot, 12);

        load_p1();
        run_prog(1'b0);
        tot = 0;
        for (int j = 0; j < 6; j++) begin
            check("R10", $sformatf("unbypassed stalls instr %0d", j), meas[j], exp_n[j]);
            tot += meas[j];
        end
        check("R10", "unbypassed last writeback cycle", 10 + tot, 16);

        load_p2();
        run_prog(1'b1);
        check("R4", "branch after load stalls", meas[7], 2);
        check("R9", "no stall past store field", meas[3], 0);
        check("R6", "no stall on r0", meas[1], 0);
        check("R10", "delay slot stalls", meas[8], 0);

        load_p2();
        run_prog(1'b0);
        check("R5", "unbypassed store after ALU", meas[2], 2);

        report();
        $finish;
    end

endmodule